// File: doc/BRIEF.md
# Pipelined 64-bit Hash Finalizer

This block takes 64-bit integer keys and turns them into 64-bit values that look unrelated to each other, even when the keys arrive as a plain count such as 0, 1, 2 and so on. A hash table can use the low bits of the result as its bucket index. Consecutive keys then go to buckets far apart, and the same bucket is not hit again and again.

The function has five steps. A right shift by 33 folded in with XOR comes first, last and in the middle. Between these sit two multiplications by fixed odd 64-bit constants, and only the low 64 bits of each product are kept. The constants are 0xFF51AFD7ED558CCD for the first multiplication and 0xC4CEB9FE1A85EC53 for the second. Every step can be undone, so the whole mapping is a bijection on 64-bit values.

Each step has its own register stage. Keys come in on a valid/ready stream and results leave on a second valid/ready stream, in the same order as the keys. When the consumer holds off, the whole pipeline freezes together and nothing is lost.

Top module: `hfin_mixer64`

## Requirements
- R1: A key of 0 produces a result of 0.
- R2: The result for key x is computed as follows. Let a = x ^ (x >> 33). Let b = low 64 bits of a * 0xFF51AFD7ED558CCD. Let c = b ^ (b >> 33). Let d = low 64 bits of c * 0xC4CEB9FE1A85EC53. The result is d ^ (d >> 33).
- R3: If out_ready stays high, a key accepted on one clock edge appears on out_valid/out_data after exactly 5 clock edges, counting that edge.
- R4: While out_ready is high, in_ready is high, so a key can be accepted on every cycle.
- R5: While out_valid is high and out_ready is low, out_valid stays high and out_data keeps its value on the next cycle, and in_ready is low.
- R6: Results leave in the order their keys were accepted. No key is dropped or duplicated, and no more than 5 keys are in flight.
- R7: A cycle with in_valid low accepts nothing. Whatever is on in_data in that cycle produces no result.
- R8: During and right after synchronous reset, out_valid is low and in_ready is high.
- R9: Distinct keys give distinct results. This is checked on a run of 64 consecutive keys.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A key is offered on in_data |
| in_ready | output | 1 | The block takes the offered key on this edge |
| in_data | input | 64 | Key to be mixed |
| out_valid | output | 1 | out_data holds a result |
| out_ready | input | 1 | The consumer takes the result on this edge |
| out_data | output | 64 | Mixed result |

## Verification
The assertions assume that in_valid is low during reset. The latency property also assumes that out_ready stays high across the five cycles it looks back over. The bench never raises in_valid until reset has been released. It changes inputs only on the falling edge, so every handshake is decided on stable values. The stall scenarios use fixed out_ready patterns that hold the pipeline full for several cycles before releasing it. Every result is compared in order against a reference model of R2 computed in the bench.

// File: rtl/hfin_pkg.sv
package hfin_pkg;

    localparam int WORD_W  = 64;
    localparam int SHIFT_R = 33;
    localparam int NSTAGE  = 5;

    localparam logic [WORD_W-1:0] MUL_A = 64'hFF51AFD7ED558CCD;
    localparam logic [WORD_W-1:0] MUL_B = 64'hC4CEB9FE1A85EC53;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        OP_XSH   = 2'd0,
        OP_MUL_A = 2'd1,
        OP_MUL_B = 2'd2
    } op_e;

    typedef struct packed {
        logic  vld;
        word_t val;
    } beat_t;

    // Step order of the finalizer: fold, multiply, fold, multiply, fold
    function automatic op_e stage_op(input int k);
        case (k)
            1:       return OP_MUL_A;
            3:       return OP_MUL_B;
            default: return OP_XSH;
        endcase
    endfunction

    function automatic word_t fold_shift(input word_t x, input int sh);
        return x ^ (x >> sh);
    endfunction

    function automatic word_t mul_low(input word_t x, input word_t k);
        return x * k;
    endfunction

endpackage

// File: rtl/hfin_flow.sv
module hfin_flow (
    input  logic last_vld,
    input  logic out_ready,
    output logic adv
);
    // The pipeline moves as a whole when the last slot is empty or drained
    always_comb begin
        adv = out_ready | ~last_vld;
    end
endmodule

// File: rtl/hfin_stage.sv
module hfin_stage
    import hfin_pkg::*;
#(
    parameter op_e OP    = OP_XSH,
    parameter int  SHIFT = SHIFT_R
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  adv,
    input  beat_t d,
    output beat_t q
);
    word_t nxt;

    generate
        if (OP == OP_XSH) begin : g_xsh
            always_comb nxt = fold_shift(d.val, SHIFT);
        end else if (OP == OP_MUL_A) begin : g_mula
            always_comb nxt = mul_low(d.val, MUL_A);
        end else begin : g_mulb
            always_comb nxt = mul_low(d.val, MUL_B);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (adv) begin
            q.vld <= d.vld;
            q.val <= nxt;
        end
    end
endmodule

// File: rtl/hfin_mixer64.sv
module hfin_mixer64
    import hfin_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [63:0] in_data,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [63:0] out_data
);
    localparam int LAST = NSTAGE;

    beat_t chain [0:LAST];
    logic  adv;

    always_comb begin
        chain[0].vld = in_valid;
        chain[0].val = in_data;
    end

    hfin_flow u_flow (
        .last_vld (chain[LAST].vld),
        .out_ready(out_ready),
        .adv      (adv)
    );

    generate
        for (genvar k = 0; k < NSTAGE; k++) begin : g_st
            hfin_stage #(
                .OP   (stage_op(k)),
                .SHIFT(SHIFT_R)
            ) u_st (
                .clk(clk),
                .rst(rst),
                .adv(adv),
                .d  (chain[k]),
                .q  (chain[k+1])
            );
        end
    endgenerate

    assign in_ready  = adv;
    assign out_valid = chain[LAST].vld;
    assign out_data  = chain[LAST].val;
endmodule

// File: rtl/hfin_mixer64_chk.sv
module hfin_mixer64_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_ready,
    input logic [63:0] in_data,
    input logic        out_valid,
    input logic        out_ready,
    input logic [63:0] out_data
);
    logic       acc, emit;
    logic [3:0] in_flight;
    logic [2:0] since_rst;

    assign acc  = in_valid & in_ready;
    assign emit = out_valid & out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_flight <= '0;
            since_rst <= '0;
        end else begin
            in_flight <= in_flight + {3'd0, acc} - {3'd0, emit};
            if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
        end
    end

    // R8: reset empties the output and leaves the input open
    assert_reset_clear_R8: assert property (@(posedge clk)
        rst |=> (!out_valid && in_ready));

    // R4: a ready consumer never blocks the input
    assert_full_rate_R4: assert property (@(posedge clk) disable iff (rst)
        out_ready |-> in_ready);

    // R5: a held result stays put and the input is closed
    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    assert_block_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    // R6: occupancy never exceeds the stage count
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        in_flight <= 4'd5);

    // R7: nothing leaves an empty pipeline
    assert_no_phantom_R7: assert property (@(posedge clk) disable iff (rst)
        (in_flight == 4'd0) |-> !out_valid);

    // R3: five edges after acceptance with the consumer ready, a result is present
    assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'd5 && $past(acc, 5) &&
         $past(out_ready, 1) && $past(out_ready, 2) && $past(out_ready, 3) &&
         $past(out_ready, 4)) |-> out_valid);

    // R1: zero key with an empty, unstalled pipeline gives a zero result
    assert_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'd5 && in_flight == 4'd1 && out_valid &&
         $past(acc, 5) && $past(in_data, 5) == 64'd0 &&
         $past(out_ready, 1) && $past(out_ready, 2) && $past(out_ready, 3) &&
         $past(out_ready, 4)) |-> (out_data == 64'd0));

endmodule

bind hfin_mixer64 hfin_mixer64_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data)
);

// File: tb/tb_hfin_mixer64.sv
module tb_hfin_mixer64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [63:0] out_data;

    int checks = 0;
    int fails  = 0;
    int n_out  = 0;
    logic [63:0] exp_q [$];
    logic [63:0] last_out = '1;
    logic [63:0] seen [0:63];

    always #4 clk = ~clk;  // 125 MHz

    hfin_mixer64 dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    function automatic logic [63:0] ref_mix(input logic [63:0] x);
        logic [63:0] h;
        h = x ^ (x >> 33);
        h = h * 64'hFF51AFD7ED558CCD;
        h = h ^ (h >> 33);
        h = h * 64'hC4CEB9FE1A85EC53;
        h = h ^ (h >> 33);
        return h;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, settle, then record the handshakes of the next edge
    task automatic step(input bit iv, input logic [63:0] d, input bit ordy);
        @(negedge clk);
        in_valid  = iv;
        in_data   = d;
        out_ready = ordy;
        #1;
        if (in_valid && in_ready) exp_q.push_back(ref_mix(d));
        if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected result", out_data, 64'd0);
            end else begin
                logic [63:0] e;
                e = exp_q.pop_front();
                check(out_data == e, "R2/R6 result", out_data, e);
            end
            if (n_out < 64) seen[n_out] = out_data;
            n_out++;
            last_out = out_data;
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 12; i++) step(1'b0, 64'hDEAD_BEEF_0BAD_F00D, 1'b1);
        check(exp_q.size() == 0, "R6 drained", 64'(exp_q.size()), 64'd0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check(out_valid == 1'b0, "R8 out_valid in reset", 64'(out_valid), 64'd0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(out_valid == 1'b0, "R8 out_valid after reset", 64'(out_valid), 64'd0);
        check(in_ready == 1'b1, "R8 in_ready after reset", 64'(in_ready), 64'd1);
    endtask

    task automatic t_zero();
        step(1'b1, 64'd0, 1'b1);
        drain();
        check(last_out == 64'd0, "R1 zero key", last_out, 64'd0);
    endtask

    task automatic t_latency();
        int wait_n;
        bit got;
        step(1'b1, 64'h0123_4567_89AB_CDEF, 1'b1);
        wait_n = 0;
        got = 1'b0;
        for (int i = 1; i <= 8 && !got; i++) begin
            step(1'b0, 64'd0, 1'b1);
            if (out_valid) begin
                got = 1'b1;
                wait_n = i;
            end
        end
        check(wait_n == 5, "R3 latency", 64'(wait_n), 64'd5);
        drain();
    endtask

    task automatic t_known_vectors();
        logic [63:0] a;
        step(1'b1, 64'd1, 1'b1);
        drain();
        a = 64'd1 ^ (64'd1 >> 33);
        a = a * 64'hFF51AFD7ED558CCD;
        a = a ^ (a >> 33);
        a = a * 64'hC4CEB9FE1A85EC53;
        a = a ^ (a >> 33);
        check(last_out == a, "R2 key one", last_out, a);
        step(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
        drain();
        check(last_out == ref_mix(64'hFFFF_FFFF_FFFF_FFFF), "R2 all ones", last_out,
              ref_mix(64'hFFFF_FFFF_FFFF_FFFF));
    endtask

    task automatic t_stream();
        int low_rdy;
        int start;
        low_rdy = 0;
        start = n_out;
        for (int i = 0; i < 64; i++) begin
            step(1'b1, 64'(i), 1'b1);
            if (!in_ready) low_rdy++;
        end
        drain();
        check(low_rdy == 0, "R4 in_ready while streaming", 64'(low_rdy), 64'd0);
        check((n_out - start) == 64, "R6 result count", 64'(n_out - start), 64'd64);
    endtask

    task automatic t_distinct();
        int dup;
        int start;
        dup = 0;
        n_out = 0;
        start = 0;
        for (int i = 0; i < 64; i++) step(1'b1, 64'h1000 + 64'(i), 1'b1);
        drain();
        for (int i = start; i < 64; i++)
            for (int j = i + 1; j < 64; j++)
                if (seen[i] == seen[j]) dup++;
        check(dup == 0, "R9 distinct results", 64'(dup), 64'd0);
    endtask

    task automatic t_backpressure();
        logic [63:0] held;
        int acc_n;
        int bad_hold;
        acc_n = 0;
        bad_hold = 0;
        for (int i = 0; i < 10; i++) begin
            step(1'b1, 64'hA5A5_0000_0000_0000 + 64'(i), 1'b0);
            if (in_ready) acc_n++;
        end
        check(acc_n == 5, "R6 fill limit", 64'(acc_n), 64'd5);
        check(in_ready == 1'b0, "R5 input closed", 64'(in_ready), 64'd0);
        held = out_data;
        for (int i = 0; i < 4; i++) begin
            step(1'b1, 64'h5555, 1'b0);
            if (!out_valid || out_data != held) bad_hold++;
        end
        check(bad_hold == 0, "R5 result held", 64'(bad_hold), 64'd0);
        for (int i = 0; i < 30; i++)
            step(1'b1, 64'hC000 + 64'(i), 1'((i % 3) != 1));
        drain();
    endtask

    task automatic t_gaps();
        int start;
        start = n_out;
        for (int i = 0; i < 20; i++)
            step(1'((i % 2) == 0), 64'h7700 + 64'(i), 1'b1);
        drain();
        check((n_out - start) == 10, "R7 gaps ignored", 64'(n_out - start), 64'd10);
    endtask

    initial begin
        t_reset();
        t_zero();
        t_latency();
        t_known_vectors();
        t_stream();
        t_distinct();
        t_backpressure();
        t_gaps();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule